// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block turns a stream of data bits into a two-level line waveform. It runs from a clock at twice the bit rate, so every bit cell has two clock periods. The first period is the lead half and the second is the trail half. The line level for both halves is worked out when the bit is taken, and that level is driven from a register.

Five codes can be selected:
- plain NRZ;
- two start-toggling codes (FM0 and FM1);
- Manchester;
- differential Manchester.

The relative codes depend on state carried from one cell to the next. The block therefore keeps the present line level and the direction of the most recent centre transition.

Bits arrive on a valid/ready stream. The encoder can take one bit per cell, so `in_ready` is high only in the cycle before a cell boundary. A producer that holds `in_valid` high keeps the line fully occupied. While `in_valid` is low the line simply holds its level, and no cell is inserted. The mode pin is plain control and is sampled together with each accepted bit.

Top module: `line_encoder`

## Requirements
- R1: `in_ready` is high whenever no cell is in progress. A bit transfers on a rising edge where `in_valid` and `in_ready` are both high. The following cycle is the trail half: `in_ready` is low and `in_valid`, `in_bit` and `mode` are ignored. After the trail half, `in_ready` is high again.
- R2: In a cycle where `in_ready` is high and `in_valid` is low, `line_out` keeps its level and no cell starts.
- R3: Mode code 0 (NRZ), and the unused codes 5, 6 and 7, drive the data bit on `line_out` for both halves of the cell.
- R4: Mode code 1 (FM0) inverts the line at the start of every cell. A 0 inverts it again for the trail half, while a 1 keeps the lead level.
- R5: Mode code 2 (FM1) inverts the line at the start of every cell. A 1 inverts it again for the trail half, while a 0 keeps the lead level.
- R6: Mode code 3 (Manchester) drives lead 1 and trail 0 for a data 1, and lead 0 and trail 1 for a data 0. When the previous level differs from the required lead level, the line changes at the cell start.
- R7: Mode code 4 (differential Manchester) always changes the line at mid-cell. For a 0 the centre transition has the same direction as the stored one; for a 1 it has the opposite direction. A rising centre transition is lead 0 and trail 1; a falling one is lead 1 and trail 0.
- R8: While `rst_n` is low, and after reset, `line_out` is 0, `in_ready` is 1 and the stored centre direction is falling.
- R9: The bit and mode that are used for a cell are those present on the accepting edge. Changes to either during the trail half have no effect on the cell in progress.
- R10: Manchester and differential Manchester cells record their centre direction. NRZ, FM0 and FM1 cells leave the recorded direction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Line code select (0 NRZ, 1 FM0, 2 FM1, 3 Manchester, 4 differential Manchester) |
| in_valid | input | 1 | Data bit offered |
| in_ready | output | 1 | Encoder can start a cell at the next edge |
| in_bit | input | 1 | Data bit |
| line_out | output | 1 | Encoded line level |

## Verification
On every cycle, the assertions check the handshake cadence, the holding of the line while idle, and the start-of-cell inversion of the FM codes. They also check the NRZ level, the trail level of Manchester, and the mid-cell change of both Manchester codes. The state carried from one cell to the next can only be shown by the bench's sweeps. That covers the stored centre direction passing through cells of other codes, FM chains that depend on the level before the cell, and the ignoring of inputs that change during the trail half. The sweeps run every 5-bit pattern under all eight mode codes.

// File: rtl/line_enc_pkg.sv
`timescale 1ns/1ps
package line_enc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LM_NRZ  = 3'd0,
    LM_FM0  = 3'd1,
    LM_FM1  = 3'd2,
    LM_MAN  = 3'd3,
    LM_DMAN = 3'd4
  } line_mode_e;

  // Levels for one bit cell plus direction bookkeeping (1 = rising centre)
  typedef struct packed {
    logic lead;
    logic trail;
    logic dir_next;
    logic dir_we;
  } cell_plan_t;
endpackage

// File: rtl/cell_phase_seq.sv
`timescale 1ns/1ps
module cell_phase_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  output logic ready_o,
  output logic accept_o,
  output logic trail_o
);
  logic in_trail_q;

  assign ready_o  = ~in_trail_q;
  assign accept_o = valid_i & ~in_trail_q;
  assign trail_o  = in_trail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) in_trail_q <= 1'b0;
    else        in_trail_q <= accept_o;
  end
endmodule

// File: rtl/cell_symbol_map.sv
`timescale 1ns/1ps
module cell_symbol_map
  import line_enc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              bit_i,
  input  logic              level_i,
  input  logic              dir_i,
  output cell_plan_t        plan_o
);
  logic dman_dir;

  // differential: a 1 flips the centre direction, a 0 repeats it
  assign dman_dir = bit_i ? ~dir_i : dir_i;

  always_comb begin
    plan_o.lead     = bit_i;
    plan_o.trail    = bit_i;
    plan_o.dir_next = dir_i;
    plan_o.dir_we   = 1'b0;
    case (mode_i)
      LM_FM0: begin
        plan_o.lead  = ~level_i;
        plan_o.trail = bit_i ? ~level_i : level_i;
      end
      LM_FM1: begin
        plan_o.lead  = ~level_i;
        plan_o.trail = bit_i ? level_i : ~level_i;
      end
      LM_MAN: begin
        plan_o.lead     = bit_i;
        plan_o.trail    = ~bit_i;
        plan_o.dir_next = ~bit_i;
        plan_o.dir_we   = 1'b1;
      end
      LM_DMAN: begin
        plan_o.lead     = ~dman_dir;
        plan_o.trail    = dman_dir;
        plan_o.dir_next = dman_dir;
        plan_o.dir_we   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/line_level_reg.sv
`timescale 1ns/1ps
module line_level_reg
  import line_enc_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0,
  parameter logic RESET_DIR   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic       trail_i,
  input  cell_plan_t plan_i,
  output logic       line_o,
  output logic       dir_o
);
  logic line_q, trail_q, dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= RESET_LEVEL;
      trail_q <= RESET_LEVEL;
      dir_q   <= RESET_DIR;
    end else if (trail_i) begin
      line_q <= trail_q;
    end else if (accept_i) begin
      line_q  <= plan_i.lead;
      trail_q <= plan_i.trail;
      if (plan_i.dir_we) dir_q <= plan_i.dir_next;
    end
  end

  assign line_o = line_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/line_encoder.sv
`timescale 1ns/1ps
module line_encoder
  import line_enc_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  output logic              line_out
);
  localparam logic DIR_FALLING = 1'b0;

  logic       accept, trail, cur_dir;
  cell_plan_t plan;

  cell_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (in_valid),
    .ready_o  (in_ready),
    .accept_o (accept),
    .trail_o  (trail)
  );

  cell_symbol_map u_map (
    .mode_i  (mode),
    .bit_i   (in_bit),
    .level_i (line_out),
    .dir_i   (cur_dir),
    .plan_o  (plan)
  );

  line_level_reg #(
    .RESET_LEVEL (RESET_LEVEL),
    .RESET_DIR   (DIR_FALLING)
  ) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .trail_i  (trail),
    .plan_i   (plan),
    .line_o   (line_out),
    .dir_o    (cur_dir)
  );
endmodule

// File: rtl/line_encoder_chk.sv
`timescale 1ns/1ps
module line_encoder_chk
  import line_enc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_bit,
  input logic              line_out
);
  logic take;
  assign take = in_valid & in_ready;

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);
  // R1
  ready_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(line_out));
  // R4
  fm_start_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (mode == LM_FM0 || mode == LM_FM1)) |=> line_out != $past(line_out));
  // R3
  nrz_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (mode == LM_NRZ || mode > LM_DMAN)) |=> line_out == $past(in_bit));
  // R6
  man_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take && mode == LM_MAN, 2) |-> line_out == !$past(in_bit, 2));
  // R7
  mid_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take && (mode == LM_MAN || mode == LM_DMAN), 2) |-> line_out != $past(line_out));
endmodule

bind line_encoder line_encoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_bit   (in_bit),
  .line_out (line_out)
);

// File: tb/line_encoder_test.sv
`timescale 1ns/1ps
module line_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready, line_out;

  int checks = 0;
  int fails  = 0;
  logic ref_level, ref_dir;

  always #2.5 clk = ~clk;

  line_encoder uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .line_out(line_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R3";
    endcase
  endfunction

  // One cell; called and returning at a falling edge
  task automatic send_cell(input logic [2:0] m, input logic b);
    logic lead, trail, nd;
    lead = b; trail = b;
    case (m)
      3'd1: begin lead = ~ref_level; trail = b ? lead : ~lead; end
      3'd2: begin lead = ~ref_level; trail = b ? ~lead : lead; end
      3'd3: begin lead = b; trail = ~b; ref_dir = ~b; end
      3'd4: begin nd = b ? ~ref_dir : ref_dir; lead = ~nd; trail = nd; ref_dir = nd; end
      default: ;
    endcase
    check("R1 ready at cell start", in_ready, 1'b1);
    mode = m; in_bit = b; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check({tag_of(m), " lead half"}, line_out, lead);
    check("R1 ready low in trail half", in_ready, 1'b0);
    // R9: disturb inputs during trail half
    mode = m ^ 3'd3; in_bit = ~b; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check({tag_of(m), " R9 trail half"}, line_out, trail);
    ref_level = trail;
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8
    check("R8 reset line", line_out, 1'b0);
    check("R8 reset ready", in_ready, 1'b1);
    rst_n = 1'b1;
    ref_level = 1'b0; ref_dir = 1'b0;
    @(negedge clk);
    // R8: falling direction after reset, a 0 repeats it
    send_cell(3'd4, 1'b0);

    // sweep every 5-bit pattern under every mode code
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 32; p++) begin
        for (int k = 0; k < 5; k++) send_cell(3'(m), p[k]);
      end
    end

    // R2: idle gaps hold the level
    for (int g = 0; g < 4; g++) begin
      @(negedge clk);
      check("R2 idle hold", line_out, ref_level);
      check("R2 idle ready", in_ready, 1'b1);
    end

    // R10: direction survives non-Manchester cells
    send_cell(3'd4, 1'b1);
    send_cell(3'd1, 1'b0);
    send_cell(3'd2, 1'b1);
    send_cell(3'd0, 1'b1);
    send_cell(3'd4, 1'b0);  // R10
    send_cell(3'd3, 1'b0);
    send_cell(3'd1, 1'b1);
    send_cell(3'd4, 1'b0);  // R10

    // mixed codes with idle cycles in between
    for (int i = 0; i < 40; i++) begin
      send_cell(3'((i * 3) % 8), ((i * 7) % 5) > 1);
      if (i % 3 == 0) begin
        @(negedge clk);
        check("R2 gap hold", line_out, ref_level);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule